// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial transceiver. One clock domain drives two independent paths. The transmit path takes a word from a one-entry buffer and moves it out on `txd`. The receive path rebuilds characters from `rxd` and hands them out with their error flags. The character shape is chosen at run time from plain configuration pins: the data width (five to nine bits), the parity mode (none, even or odd) and the stop length (one or two bits). A 12-bit divider sets the bit rate. A double-speed pin halves the number of oversampling ticks in each bit.

Both data paths use valid/ready. A transmit word is taken on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the buffer holds a word that has not yet reached the shift register, so the writer holds `tx_valid` and `tx_data` until then. It doubles as the transmit-buffer-empty status. A received character is offered with `rx_valid`, which is also the receive-complete status. Data and flags stay fixed until `rx_ready` is seen high. The receiver does not wait for the reader. A character that ends while the previous one is still being offered is discarded, and the overrun flag is raised. The configuration pins must be held steady while either path is busy.

Top module: `serial_xcvr`

## Requirements
- R1: `cfg_bits` codes 0 to 4 select 5 to 9 data bits. On the line a frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. `rx_data` holds the received bits right-justified, with the unused upper bits at zero.
- R2: When `cfg_stop2` is 1 the transmitter sends two stop bits, and one otherwise. Back-to-back frames therefore start exactly (1 + data bits + parity bit + stop bits) bit periods apart.
- R3: `cfg_par` selects the parity: 0 or 1 none, 2 even, 3 odd. Under even parity the data bits plus the parity bit hold an even number of ones. The transmitter inserts the parity bit. The receiver raises `rx_perr` with the word when the received parity bit disagrees.
- R4: When the first stop bit is voted low, the receiver raises `rx_ferr` with the word.
- R5: When a character completes while `rx_valid` is high and `rx_ready` is low, the new character is dropped, `rx_data` keeps the older word and `rx_overrun` goes high. `rx_overrun` clears on the next read handshake.
- R6: A falling edge on `rxd` whose start bit is not voted low at mid-bit is discarded, and no word is produced.
- R7: Each received bit is the majority of three samples at the centre of the bit. A disturbance that covers only one sample period does not change the result.
- R8: One bit lasts (`cfg_div` + 1) × 16 clock cycles, or (`cfg_div` + 1) × 8 cycles when `cfg_dbl` is 1.
- R9: The transmit buffer holds one word. `tx_ready` goes low only when a word is taken, and stays low until that word moves into the shift register.
- R10: `tx_done` rises when the last stop bit has left and no word is waiting, stays high while idle, and clears when a new word is taken. It never rises between frames of a back-to-back burst.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and the flags stay unchanged. A handshake drops `rx_valid` on the next cycle unless a new word arrives in that same cycle.
- R12: After reset `txd` is high, `tx_ready` is high, and `tx_done`, `rx_valid` and `rx_overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 12 | Divider reload value; oversample tick every cfg_div+1 clocks |
| cfg_dbl | input | 1 | Double-speed mode (8 ticks per bit instead of 16) |
| cfg_bits | input | 3 | Data width code, 0..4 for 5..9 bits |
| cfg_par | input | 2 | Parity mode: 0/1 none, 2 even, 3 odd |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty, word can be taken |
| tx_data | input | 9 | Transmit word, low bits used |
| txd | output | 1 | Serial output, idles high |
| tx_done | output | 1 | Transmission complete, nothing pending |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received word available (receive complete) |
| rx_ready | input | 1 | Reader takes the word |
| rx_data | output | 9 | Received word, right-justified |
| rx_perr | output | 1 | Parity error for the offered word |
| rx_ferr | output | 1 | Framing error for the offered word |
| rx_overrun | output | 1 | A word was dropped while the previous one was unread |

## Verification
Some rules are checked on every cycle by the assertions. The receive word and flags must stay stable under back-pressure. An overrun may only appear while a word is being held. The transmit buffer may fill only when a word is offered. `tx_done` must never be high while a word waits. Oversample ticks must never run back to back when the divider is nonzero. The other behaviours need the bench's scenarios. These are the exact bit and frame durations in both speed modes, the bit order and parity over the five data widths, and the rejection of a false start. They also cover the survival of a one-tick glitch, the framing and parity errors injected on the line, and the drop of a second unread character.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  localparam int MAX_BITS = 9;
  localparam int NB_W     = 4;

  typedef enum logic [2:0] {FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP} frame_st_e;

  // Width code 0..4 -> 5..9 data bits; larger codes saturate at 9.
  function automatic logic [NB_W-1:0] bits_of(input logic [2:0] code);
    return (code > 3'd4) ? NB_W'(MAX_BITS) : NB_W'(code) + NB_W'(5);
  endfunction

  // Parity over the low n bits; odd=1 makes the total count of ones odd.
  function automatic logic par_of(input logic [MAX_BITS-1:0] d,
                                  input logic [NB_W-1:0] n,
                                  input logic odd);
    logic [MAX_BITS-1:0] m;
    logic [NB_W-1:0]     sh;
    sh = NB_W'(MAX_BITS) - n;
    m  = '1;
    m  = m >> sh;
    return (^(d & m)) ^ odd;
  endfunction
endpackage

// File: rtl/sxc_baud.sv
module sxc_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/sxc_tx.sv
module sxc_tx import sxc_pkg::*; #(
  parameter int DW   = MAX_BITS,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] os_last,
  input  logic [NB_W-1:0] nbits,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            stop2,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [DW-1:0]   tx_data,
  output logic            txd,
  output logic            tx_done
);
  frame_st_e       st;
  logic [DW-1:0]   buf_q, sh;
  logic            buf_full, pbit, done;
  logic [NB_W-1:0] idx;
  logic [PH_W-1:0] ph;
  logic            acc, end_frame, ld;

  assign acc       = tx_valid && !buf_full;
  assign end_frame = (st == FR_STOP) && tick && (ph == os_last) && !(stop2 && idx == '0);
  assign ld        = buf_full && (((st == FR_IDLE) && tick) || end_frame);
  assign tx_ready  = !buf_full;
  assign tx_done   = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_IDLE; buf_q <= '0; sh <= '0; buf_full <= 1'b0;
      pbit <= 1'b0; done <= 1'b0; idx <= '0; ph <= '0;
    end else begin
      if (acc) begin
        buf_q    <= tx_data;
        buf_full <= 1'b1;
        done     <= 1'b0;
      end
      if (ld) begin
        buf_full <= 1'b0;
        sh       <= buf_q;
        pbit     <= par_of(buf_q, nbits, par_odd);
        st       <= FR_START;
        ph       <= '0;
        idx      <= '0;
      end else if (st != FR_IDLE && tick) begin
        if (ph == os_last) begin
          ph <= '0;
          case (st)
            FR_START: st <= FR_DATA;
            FR_DATA: begin
              sh <= sh >> 1;
              if (idx == nbits - 1'b1) begin
                idx <= '0;
                st  <= par_en ? FR_PAR : FR_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end
            FR_PAR: st <= FR_STOP;
            FR_STOP: begin
              if (stop2 && idx == '0) begin
                idx <= idx + 1'b1;
              end else begin
                st <= FR_IDLE;
                if (!acc) done <= 1'b1;
              end
            end
            default: st <= FR_IDLE;
          endcase
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (st)
      FR_START: txd = 1'b0;
      FR_DATA:  txd = sh[0];
      FR_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  assert_fill_needs_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));
  assert_done_only_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_ready);
endmodule

// File: rtl/sxc_rx.sv
module sxc_rx import sxc_pkg::*; #(
  parameter int DW   = MAX_BITS,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] os_last,
  input  logic [PH_W-1:0] mid,
  input  logic [NB_W-1:0] nbits,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            rxd,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            rx_perr,
  output logic            rx_ferr,
  output logic            rx_overrun
);
  frame_st_e       st;
  logic            s1, s2, v0, v1, pbit_r, maj, fin;
  logic [DW-1:0]   dat;
  logic [NB_W-1:0] idx;
  logic [PH_W-1:0] ph, nph;

  assign nph = (ph == os_last) ? '0 : ph + 1'b1;
  assign maj = (v0 & v1) | (v0 & s2) | (v1 & s2);
  assign fin = (st == FR_STOP) && tick && (nph == mid + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_IDLE; ph <= '0; idx <= '0; dat <= '0;
      v0 <= 1'b1; v1 <= 1'b1; pbit_r <= 1'b0;
    end else if (st == FR_IDLE) begin
      if (tick && !s2) begin
        st  <= FR_START;
        ph  <= '0;
        idx <= '0;
        dat <= '0;
      end
    end else if (tick) begin
      ph <= nph;
      if (nph == mid - 1'b1) v0 <= s2;
      if (nph == mid)        v1 <= s2;
      if (nph == mid + 1'b1) begin
        case (st)
          FR_START: if (maj) st <= FR_IDLE;
          FR_DATA:  dat[idx] <= maj;
          FR_PAR:   pbit_r <= maj;
          default:  st <= FR_IDLE;
        endcase
      end else if (nph == '0) begin
        case (st)
          FR_START: st <= FR_DATA;
          FR_DATA: begin
            if (idx == nbits - 1'b1) begin
              idx <= '0;
              st  <= par_en ? FR_PAR : FR_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          FR_PAR:  st <= FR_STOP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0;
      rx_ferr <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid   <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (fin) begin
        if (!rx_valid || rx_ready) begin
          rx_valid <= 1'b1;
          rx_data  <= dat;
          rx_perr  <= par_en && (pbit_r != par_of(dat, nbits, par_odd));
          rx_ferr  <= !maj;
        end else begin
          rx_overrun <= 1'b1;
        end
      end
    end
  end

  assert_hold_under_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)));
  assert_overrun_needs_held_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid && !rx_ready));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr import sxc_pkg::*; #(
  parameter int DIV_W = 12,
  parameter int OS_N  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_dbl,
  input  logic [2:0]          cfg_bits,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                txd,
  output logic                tx_done,
  input  logic                rxd,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_perr,
  output logic                rx_ferr,
  output logic                rx_overrun
);
  localparam int PH_W = $clog2(OS_N);

  logic            tick;
  logic [PH_W-1:0] os_last, mid;
  logic [NB_W-1:0] nbits;

  assign os_last = cfg_dbl ? PH_W'(OS_N/2 - 1) : PH_W'(OS_N - 1);
  assign mid     = cfg_dbl ? PH_W'(OS_N/4)     : PH_W'(OS_N/2);
  assign nbits   = bits_of(cfg_bits);

  sxc_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick));

  sxc_tx #(.DW(MAX_BITS), .PH_W(PH_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .os_last(os_last), .nbits(nbits),
    .par_en(cfg_par[1]), .par_odd(cfg_par[0]), .stop2(cfg_stop2),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txd(txd), .tx_done(tx_done));

  sxc_rx #(.DW(MAX_BITS), .PH_W(PH_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .os_last(os_last), .mid(mid),
    .nbits(nbits), .par_en(cfg_par[1]), .par_odd(cfg_par[0]), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_overrun(rx_overrun));
endmodule

// File: tb/serial_xcvr_tb_top.sv
module serial_xcvr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] cfg_div = 12'd3;
  logic        cfg_dbl = 1'b0;
  logic [2:0]  cfg_bits = 3'd3;
  logic [1:0]  cfg_par = 2'd0;
  logic        cfg_stop2 = 1'b0;
  logic        tx_valid = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        rx_ready = 1'b0;
  logic        loop_en = 1'b1;
  logic        drv = 1'b1;
  wire         rxd_w;
  logic        tx_ready, txd, tx_done, rx_valid, rx_perr, rx_ferr, rx_overrun;
  logic [8:0]  rx_data;

  assign rxd_w = loop_en ? txd : drv;

  serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbl(cfg_dbl),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txd(txd), .tx_done(tx_done), .rxd(rxd_w), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_overrun(rx_overrun));

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int cyc = 0, last_fall = 0, prev_fall = 0, last_rise = 0, done_rises = 0;
  logic done_q = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    done_q <= tx_done;
    if (rst_n && tx_done && !done_q) done_rises <= done_rises + 1;
  end
  always @(negedge txd) if (rst_n) begin prev_fall = last_fall; last_fall = cyc; end
  always @(posedge txd) if (rst_n) last_rise = cyc;

  function automatic int bp();
    return (int'(cfg_div) + 1) * (cfg_dbl ? 8 : 16);
  endfunction
  function automatic int nb();
    return (cfg_bits > 3'd4) ? 9 : int'(cfg_bits) + 5;
  endfunction
  function automatic logic [8:0] mask(input logic [8:0] d, input int n);
    return d & 9'((1 << n) - 1);
  endfunction
  function automatic logic exp_par(input logic [8:0] d, input int n, input logic odd);
    logic p = odd;
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    for (int i = 0; i < 20000; i++) begin
      if (tx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !tx_done; i++) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    drv = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic drv_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop, input int glitch);
    int n, b;
    n = nb(); b = bp();
    @(negedge clk);
    hold(1'b0, b);
    for (int i = 0; i < n; i++) begin
      if (i == glitch) begin
        hold(d[i], b/2);
        hold(!d[i], int'(cfg_div) + 1);
        hold(d[i], b - b/2 - (int'(cfg_div) + 1));
      end else hold(d[i], b);
    end
    if (cfg_par[1]) hold(exp_par(d, n, cfg_par[0]) ^ bad_par, b);
    if (bad_stop) begin hold(1'b0, b*3/4); hold(1'b1, b - b*3/4); end
    else hold(1'b1, b * (cfg_stop2 ? 2 : 1));
  endtask

  task automatic read_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic expect_rx(input string req, input logic [8:0] d, input bit pe, input bit fe);
    int i;
    for (i = 0; i < 30000 && !rx_valid; i++) @(negedge clk);
    chk(rx_valid == 1'b1, {req, " word arrives"}, int'(rx_valid), 1);
    chk(rx_data == d, {req, " data"}, int'(rx_data), int'(d));
    chk(rx_perr == pe, "R3 parity flag", int'(rx_perr), int'(pe));
    chk(rx_ferr == fe, "R4 framing flag", int'(rx_ferr), int'(fe));
    read_rx();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(txd == 1'b1, "R12 txd idle", int'(txd), 1);
    chk(tx_ready == 1'b1, "R12 tx_ready", int'(tx_ready), 1);
    chk(tx_done == 1'b0, "R12 tx_done", int'(tx_done), 0);
    chk(rx_valid == 1'b0, "R12 rx_valid", int'(rx_valid), 0);
    chk(rx_overrun == 1'b0, "R12 rx_overrun", int'(rx_overrun), 0);

    // R8: start bit width in both speed modes (all-ones data, no parity)
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      cfg_dbl = m[0]; cfg_bits = 3'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0;
      push(9'h0FF);
      wait_done();
      chk(last_rise - last_fall == bp(), "R8 bit period", last_rise - last_fall, bp());
      expect_rx("R1", 9'h0FF, 1'b0, 1'b0);
    end

    // R9, R10, R2: back-to-back burst with two stop bits
    @(negedge clk);
    cfg_dbl = 1'b0; cfg_stop2 = 1'b1; rx_ready = 1'b1;
    done_rises = 0;
    push(9'h0FF);
    push(9'h0FF);
    chk(tx_ready == 1'b0, "R9 buffer full while first word shifts", int'(tx_ready), 0);
    chk(tx_done == 1'b0, "R10 done cleared by accept", int'(tx_done), 0);
    wait_done();
    repeat (4) @(negedge clk);
    chk(last_fall - prev_fall == 11 * bp(), "R2 frame spacing two stops", last_fall - prev_fall, 11 * bp());
    chk(done_rises == 1, "R10 single done per burst", done_rises, 1);
    rx_ready = 1'b0;
    @(negedge clk);
    cfg_stop2 = 1'b0;
    push(9'h0FF);
    push(9'h0FF);
    wait_done();
    chk(last_fall - prev_fall == 10 * bp(), "R2 frame spacing one stop", last_fall - prev_fall, 10 * bp());
    rx_ready = 1'b1; repeat (2) @(negedge clk); rx_ready = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R11 drained", int'(rx_valid), 0);

    // R1: widest and narrowest data fields, upper bits dropped
    @(negedge clk); cfg_bits = 3'd4; cfg_par = 2'd2;
    push(9'h1A5); wait_done(); expect_rx("R1 nine bits", 9'h1A5, 1'b0, 1'b0);
    @(negedge clk); cfg_bits = 3'd0; cfg_par = 2'd3;
    push(9'h1F6); wait_done(); expect_rx("R1 five bits", 9'h016, 1'b0, 1'b0);

    // Random loopback over formats and speeds (R1, R3, R8, R10)
    for (int it = 0; it < 24; it++) begin
      @(negedge clk);
      cfg_bits = 3'($urandom_range(0, 4));
      cfg_par = 2'($urandom_range(0, 3));
      cfg_stop2 = 1'($urandom_range(0, 1));
      cfg_dbl = 1'($urandom_range(0, 1));
      d = 9'($urandom_range(0, 511));
      n = nb();
      push(d);
      chk(tx_done == 1'b0, "R10 cleared on accept", int'(tx_done), 0);
      expect_rx("R1 random", mask(d, n), 1'b0, 1'b0);
      wait_done();
      chk(tx_done == 1'b1, "R10 done after frame", int'(tx_done), 1);
    end

    // Directed receive cases driven by the bench
    @(negedge clk);
    loop_en = 1'b0; drv = 1'b1;
    cfg_dbl = 1'b0; cfg_bits = 3'd3; cfg_par = 2'd2; cfg_stop2 = 1'b0;
    repeat (20) @(negedge clk);

    // R3: wrong parity bit on the line
    drv_frame(9'h0C3, 1'b1, 1'b0, -1);
    expect_rx("R3 bad parity", 9'h0C3, 1'b1, 1'b0);

    // R4: stop bit low
    drv_frame(9'h05A, 1'b0, 1'b1, -1);
    expect_rx("R4 bad stop", 9'h05A, 1'b0, 1'b1);
    repeat (3 * bp()) @(negedge clk);

    // R7: one-tick glitch inside a data bit
    drv_frame(9'h0F0, 1'b0, 1'b0, 2);
    expect_rx("R7 glitch filtered", 9'h0F0, 1'b0, 1'b0);

    // R6: short low pulse is a false start
    @(negedge clk);
    hold(1'b0, 3 * (int'(cfg_div) + 1));
    hold(1'b1, 12 * bp());
    chk(rx_valid == 1'b0, "R6 false start discarded", int'(rx_valid), 0);
    drv_frame(9'h081, 1'b0, 1'b0, -1);
    expect_rx("R6 next frame intact", 9'h081, 1'b0, 1'b0);

    // R5 and R11: second frame while first is unread
    drv_frame(9'h011, 1'b0, 1'b0, -1);
    drv_frame(9'h0EE, 1'b0, 1'b0, -1);
    repeat (4) @(negedge clk);
    chk(rx_overrun == 1'b1, "R5 overrun raised", int'(rx_overrun), 1);
    chk(rx_data == 9'h011, "R5 older word kept", int'(rx_data), 'h11);
    chk(rx_valid == 1'b1, "R11 word held", int'(rx_valid), 1);
    read_rx();
    chk(rx_valid == 1'b0, "R11 valid drops after read", int'(rx_valid), 0);
    chk(rx_overrun == 1'b0, "R5 overrun cleared by read", int'(rx_overrun), 0);

    // R8: double-speed receive of a driven frame
    @(negedge clk); cfg_dbl = 1'b1; cfg_par = 2'd3; cfg_stop2 = 1'b1;
    repeat (10) @(negedge clk);
    drv_frame(9'h03C, 1'b0, 1'b0, -1);
    expect_rx("R8 double speed receive", 9'h03C, 1'b0, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule